// File: doc/BRIEF.md
# Index-Prefixed Second-Byte Decoder

This block classifies the byte that follows an index-register prefix on an 8-bit processor. A fetch unit presents that byte on `opByte` with a one-cycle `opValid` strobe. One clock later the block returns a registered decode bundle with a `decDone` pulse. The bundle contains:

- an operation class;
- 8-bit source and destination selects, with the index-register halves substituted for H and L where the register form needs it;
- an ALU operation or inc/dec direction, plus a register-pair select for the 16-bit add;
- whether a displacement byte follows, and how many immediate bytes follow;
- the total cycle count of the instruction.

The block does not execute anything and does not fetch from memory. Opcodes outside the prefixed set are reported as fall-through, so the plain decoder can handle them unchanged. The bit-operation sub-prefix is reported as a handoff.

The bundle holds its value until the next strobe. Encodings used by all outputs:

- Class codes: NOP=0, MOVE=1, ALU=2, ADD16=3, LDST=4, STACK=5, JUMP=6, INCDEC=7, SUBPFX=8, FALL=9.
- Register selects: 0..7 = B, C, D, E, H, L, indexed memory, A; 8 = index high byte; 9 = index low byte; 15 = none.

Top module: `idxPrefixDecoder`

## Requirements
- R1: After reset, `decDone`=0, class NOP (0), both selects 15, `aluOp`=0, `pairSel`=0, `needDisp`=0, `immBytes`=0 and `cycleCount`=0.
- R2: The bundle and a `decDone`=1 appear on the first rising edge after the one that sampled `opValid`=1. `decDone` is 0 after any edge that sampled `opValid`=0, and the bundle then keeps its previous value.
- R3: In the 0x40-0x7F register-to-register forms, field code 4 maps to select 8 and code 5 to select 9. The class is MOVE, the cycle count is 8, the source is bits 2:0 and the destination is bits 5:3. 0x40 also decodes as MOVE B to B with 8 cycles.
- R4: In the 0x40-0x7F forms where either field is 6, the class is LDST, `needDisp`=1 and the cycle count is 19. The other operand keeps plain H (4) or L (5). Opcode 0x76 is fall-through.
- R5: In 0x80-0xBF with bits 2:0 equal to 4, 5 or 6, the class is ALU and `aluOp` equals bits 5:3 (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP). The destination is A (7) and the source is 8, 9 or 6 respectively. The cycle count is 8 for the index halves and 19 with `needDisp`=1 for memory. Other low codes are fall-through.
- R6: 0x09, 0x19, 0x29 and 0x39 decode as ADD16 with `pairSel` equal to bits 5:4 and 15 cycles.
- R7: 0x21 is LDST with 2 immediate bytes and 14 cycles. 0x22 and 0x2A are LDST with 2 immediate bytes and 20 cycles. 0x26 and 0x2E are LDST with 1 immediate byte, 11 cycles and destination 8 or 9. 0xF9 is LDST with 10 cycles.
- R8: 0x36 needs a displacement byte and then one immediate byte (`needDisp`=1, `immBytes`=1). Its destination is 6 and it takes 19 cycles.
- R9: 0xE1 is STACK with 14 cycles, 0xE5 is STACK with 15 and 0xE3 is STACK with 23. 0xE9 is JUMP with 8 cycles.
- R10: 0x23 and 0x2B are INCDEC with 10 cycles. 0x24/0x25 and 0x2C/0x2D are INCDEC with 8 cycles on select 8 or 9. 0x34/0x35 are INCDEC on select 6 with `needDisp`=1 and 23 cycles. `aluOp` is 0 for increment and 1 for decrement.
- R11: 0xCB is SUBPFX with `needDisp`=1 and cycle count 0. 0x00, 0xDD and 0xFD are NOP with 8 cycles.
- R12: Every opcode not named in R3-R11 is FALL, with cycle count 0, no displacement, no immediate bytes and both selects 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Strobe: `opByte` holds a second byte to decode |
| opByte | input | 8 | Byte following the index prefix |
| decDone | output | 1 | One-cycle pulse marking a fresh decode bundle |
| opClass | output | 4 | Operation class code |
| srcSel | output | 4 | Source operand select |
| dstSel | output | 4 | Destination operand select |
| aluOp | output | 3 | ALU operation, or inc/dec direction |
| pairSel | output | 2 | Register pair added to the index register |
| needDisp | output | 1 | A displacement byte follows |
| immBytes | output | 2 | Number of immediate bytes that follow |
| cycleCount | output | 5 | Total cycle count of the instruction |

## Verification
The decode bundle is registered in one stage, so a wrong decode shows at the ports on the cycle after the strobe, together with `decDone`. A stuck or mistimed capture register shows either as a missing or extra done pulse, or as a bundle that changes without a strobe.

A bad substitution rule shows as selects 8/9 where 4/5 belong, which happens in the memory forms. A bad table entry shows as a wrong class or cycle count. An exhaustive sweep of all 256 byte values catches opcodes wrongly claimed or wrongly passed on. Directed cases pin down the cycle counts and the operand order.

// File: rtl/idxPrefixDecoder_pkg.sv
package idxPrefixDecoder_pkg;

  localparam int OP_W    = 8;
  localparam int SEL_W   = 4;
  localparam int CYC_W   = 5;
  localparam int CLASS_W = 4;

  typedef enum logic [CLASS_W-1:0] {
    CL_NOP    = 4'd0,
    CL_MOVE   = 4'd1,
    CL_ALU    = 4'd2,
    CL_ADD16  = 4'd3,
    CL_LDST   = 4'd4,
    CL_STACK  = 4'd5,
    CL_JUMP   = 4'd6,
    CL_INCDEC = 4'd7,
    CL_SUBPFX = 4'd8,
    CL_FALL   = 4'd9
  } opClass_e;

  localparam logic [SEL_W-1:0] SEL_MEM  = 4'd6;
  localparam logic [SEL_W-1:0] SEL_A    = 4'd7;
  localparam logic [SEL_W-1:0] SEL_IXH  = 4'd8;
  localparam logic [SEL_W-1:0] SEL_IXL  = 4'd9;
  localparam logic [SEL_W-1:0] SEL_NONE = 4'd15;

  typedef struct packed {
    opClass_e         cls;
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    logic [2:0]       alu;
    logic [1:0]       pair;
    logic             disp;
    logic [1:0]       imm;
    logic [CYC_W-1:0] cyc;
  } decRec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic done;
  } ctrlStrb_t;

endpackage

// File: rtl/idxPrefixCtrl.sv
module idxPrefixCtrl
  import idxPrefixDecoder_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      opValid,
  output ctrlStrb_t strb
);

  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= opValid;
  end

  always_comb begin
    strb.capture = opValid && rstN;
    strb.done    = doneQ;
  end

endmodule

// File: rtl/idxHalfMap.sv
module idxHalfMap
  import idxPrefixDecoder_pkg::*;
(
  input  logic [2:0]       fieldCode,
  input  logic             substEn,
  output logic [SEL_W-1:0] selOut
);

  always_comb begin
    if (substEn && fieldCode == 3'd4)      selOut = SEL_IXH;
    else if (substEn && fieldCode == 3'd5) selOut = SEL_IXL;
    else                                   selOut = {1'b0, fieldCode};
  end

endmodule

// File: rtl/idxPrefixDatapath.sv
module idxPrefixDatapath
  import idxPrefixDecoder_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [OP_W-1:0]  opByte,
  output logic             decDone,
  output logic [CLASS_W-1:0] opClass,
  output logic [SEL_W-1:0] srcSel,
  output logic [SEL_W-1:0] dstSel,
  output logic [2:0]       aluOp,
  output logic [1:0]       pairSel,
  output logic             needDisp,
  output logic [1:0]       immBytes,
  output logic [CYC_W-1:0] cycleCount
);

  localparam int NUM_FIELDS = 2;

  logic [2:0]       hiField, loField;
  logic             moveGrp, aluGrp, memForm, substEn;
  logic             hiHit, loHit;
  logic [2:0]       fieldIn [NUM_FIELDS];
  logic [SEL_W-1:0] mapOut  [NUM_FIELDS];
  decRec_t          nxt, cur;

  assign hiField = opByte[5:3];
  assign loField = opByte[2:0];
  assign moveGrp = (opByte[7:6] == 2'b01);
  assign aluGrp  = (opByte[7:6] == 2'b10);
  assign memForm = moveGrp && (hiField == 3'd6 || loField == 3'd6);
  assign substEn = !memForm;
  assign hiHit   = (hiField >= 3'd4) && (hiField <= 3'd6);
  assign loHit   = (loField >= 3'd4) && (loField <= 3'd6);
  assign fieldIn[0] = loField;
  assign fieldIn[1] = hiField;

  // index 0 maps the source field, index 1 the destination field
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_map
    idxHalfMap u_map (
      .fieldCode(fieldIn[g]),
      .substEn  (substEn),
      .selOut   (mapOut[g])
    );
  end

  always_comb begin
    nxt      = '0;
    nxt.cls  = CL_FALL;
    nxt.src  = SEL_NONE;
    nxt.dst  = SEL_NONE;
    if (moveGrp) begin
      if (opByte == 8'h76) begin
        nxt.cls = CL_FALL;
      end else if (opByte == 8'h40) begin
        nxt.cls = CL_MOVE;
        nxt.src = 4'd0;
        nxt.dst = 4'd0;
        nxt.cyc = 5'd8;
      end else if (hiHit || loHit) begin
        nxt.src = mapOut[0];
        nxt.dst = mapOut[1];
        if (memForm) begin
          nxt.cls  = CL_LDST;
          nxt.disp = 1'b1;
          nxt.cyc  = 5'd19;
        end else begin
          nxt.cls  = CL_MOVE;
          nxt.cyc  = 5'd8;
        end
      end
    end else if (aluGrp) begin
      if (loHit) begin
        nxt.cls  = CL_ALU;
        nxt.alu  = hiField;
        nxt.src  = mapOut[0];
        nxt.dst  = SEL_A;
        nxt.disp = (loField == 3'd6);
        nxt.cyc  = (loField == 3'd6) ? 5'd19 : 5'd8;
      end
    end else begin
      case (opByte)
        8'h09, 8'h19, 8'h29, 8'h39: begin
          nxt.cls  = CL_ADD16;
          nxt.pair = opByte[5:4];
          nxt.cyc  = 5'd15;
        end
        8'h21: begin
          nxt.cls = CL_LDST;
          nxt.imm = 2'd2;
          nxt.cyc = 5'd14;
        end
        8'h22, 8'h2A: begin
          nxt.cls = CL_LDST;
          nxt.imm = 2'd2;
          nxt.cyc = 5'd20;
        end
        8'h26, 8'h2E: begin
          nxt.cls = CL_LDST;
          nxt.imm = 2'd1;
          nxt.dst = opByte[3] ? SEL_IXL : SEL_IXH;
          nxt.cyc = 5'd11;
        end
        8'hF9: begin
          nxt.cls = CL_LDST;
          nxt.cyc = 5'd10;
        end
        8'h36: begin
          nxt.cls  = CL_LDST;
          nxt.disp = 1'b1;
          nxt.imm  = 2'd1;
          nxt.dst  = SEL_MEM;
          nxt.cyc  = 5'd19;
        end
        8'h23, 8'h2B: begin
          nxt.cls = CL_INCDEC;
          nxt.alu = {2'b00, opByte[3]};
          nxt.cyc = 5'd10;
        end
        8'h24, 8'h25, 8'h2C, 8'h2D: begin
          nxt.cls = CL_INCDEC;
          nxt.alu = {2'b00, opByte[0]};
          nxt.src = opByte[3] ? SEL_IXL : SEL_IXH;
          nxt.dst = opByte[3] ? SEL_IXL : SEL_IXH;
          nxt.cyc = 5'd8;
        end
        8'h34, 8'h35: begin
          nxt.cls  = CL_INCDEC;
          nxt.alu  = {2'b00, opByte[0]};
          nxt.src  = SEL_MEM;
          nxt.dst  = SEL_MEM;
          nxt.disp = 1'b1;
          nxt.cyc  = 5'd23;
        end
        8'hE1: begin
          nxt.cls = CL_STACK;
          nxt.cyc = 5'd14;
        end
        8'hE5: begin
          nxt.cls = CL_STACK;
          nxt.cyc = 5'd15;
        end
        8'hE3: begin
          nxt.cls = CL_STACK;
          nxt.cyc = 5'd23;
        end
        8'hE9: begin
          nxt.cls = CL_JUMP;
          nxt.cyc = 5'd8;
        end
        8'hCB: begin
          nxt.cls  = CL_SUBPFX;
          nxt.disp = 1'b1;
        end
        8'h00, 8'hDD, 8'hFD: begin
          nxt.cls = CL_NOP;
          nxt.cyc = 5'd8;
        end
        default: nxt.cls = CL_FALL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cur     <= '0;
      cur.cls <= CL_NOP;
      cur.src <= SEL_NONE;
      cur.dst <= SEL_NONE;
    end else if (strb.capture) begin
      cur <= nxt;
    end
  end

  assign decDone    = strb.done;
  assign opClass    = cur.cls;
  assign srcSel     = cur.src;
  assign dstSel     = cur.dst;
  assign aluOp      = cur.alu;
  assign pairSel    = cur.pair;
  assign needDisp   = cur.disp;
  assign immBytes   = cur.imm;
  assign cycleCount = cur.cyc;

endmodule

// File: rtl/idxPrefixDecoder.sv
module idxPrefixDecoder
  import idxPrefixDecoder_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opByte,
  output logic       decDone,
  output logic [3:0] opClass,
  output logic [3:0] srcSel,
  output logic [3:0] dstSel,
  output logic [2:0] aluOp,
  output logic [1:0] pairSel,
  output logic       needDisp,
  output logic [1:0] immBytes,
  output logic [4:0] cycleCount
);

  ctrlStrb_t strb;

  idxPrefixCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .strb   (strb)
  );

  idxPrefixDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opByte    (opByte),
    .decDone   (decDone),
    .opClass   (opClass),
    .srcSel    (srcSel),
    .dstSel    (dstSel),
    .aluOp     (aluOp),
    .pairSel   (pairSel),
    .needDisp  (needDisp),
    .immBytes  (immBytes),
    .cycleCount(cycleCount)
  );

endmodule

// File: rtl/idxPrefixDecoderChk.sv
module idxPrefixDecoderChk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [7:0] opByte,
  input logic       decDone,
  input logic [3:0] opClass,
  input logic [3:0] srcSel,
  input logic [3:0] dstSel,
  input logic       needDisp,
  input logic [1:0] immBytes,
  input logic [4:0] cycleCount
);

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> decDone);

  assert_no_spurious_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !decDone);

  assert_hold_without_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(opClass) && $stable(cycleCount) && $stable(srcSel) && $stable(dstSel)));

  assert_mem_needs_disp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (decDone && (srcSel == 4'd6 || dstSel == 4'd6)) |-> needDisp);

  assert_alu_into_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (decDone && opClass == 4'd2) |-> dstSel == 4'd7);

  assert_jump_decode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opByte == 8'hE9) |=> (opClass == 4'd6 && cycleCount == 5'd8));

  assert_fall_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (decDone && opClass == 4'd9) |-> (cycleCount == 5'd0 && !needDisp && immBytes == 2'd0));

endmodule

bind idxPrefixDecoder idxPrefixDecoderChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opByte    (opByte),
  .decDone   (decDone),
  .opClass   (opClass),
  .srcSel    (srcSel),
  .dstSel    (dstSel),
  .needDisp  (needDisp),
  .immBytes  (immBytes),
  .cycleCount(cycleCount)
);

// File: tb/idxPrefixDecoder_bench.sv
module idxPrefixDecoder_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic       decDone;
  logic [3:0] opClass, srcSel, dstSel;
  logic [2:0] aluOp;
  logic [1:0] pairSel, immBytes;
  logic       needDisp;
  logic [4:0] cycleCount;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idxPrefixDecoder u_idxPrefixDecoder (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opByte(opByte),
    .decDone(decDone), .opClass(opClass), .srcSel(srcSel), .dstSel(dstSel),
    .aluOp(aluOp), .pairSel(pairSel), .needDisp(needDisp),
    .immBytes(immBytes), .cycleCount(cycleCount)
  );

  localparam logic [3:0] NONE = 4'd15;

  // compare a full decode bundle
  task automatic chk(input string tag, input logic [7:0] op,
                     input logic [3:0] eCls, input logic [3:0] eSrc,
                     input logic [3:0] eDst, input logic [2:0] eAlu,
                     input logic [1:0] ePair, input logic eDisp,
                     input logic [1:0] eImm, input logic [4:0] eCyc);
    logic [26:0] act, exp;
    act = {decDone, opClass, srcSel, dstSel, aluOp, pairSel, needDisp, immBytes, cycleCount};
    exp = {1'b1, eCls, eSrc, eDst, eAlu, ePair, eDisp, eImm, eCyc};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%02h act done=%0b cls=%0d src=%0d dst=%0d alu=%0d pair=%0d disp=%0b imm=%0d cyc=%0d exp done=1 cls=%0d src=%0d dst=%0d alu=%0d pair=%0d disp=%0b imm=%0d cyc=%0d",
               tag, op, decDone, opClass, srcSel, dstSel, aluOp, pairSel, needDisp, immBytes, cycleCount,
               eCls, eSrc, eDst, eAlu, ePair, eDisp, eImm, eCyc);
    end
  endtask

  // present one byte; returns at the negedge after the capture edge
  task automatic issue(input logic [7:0] op);
    @(negedge clk);
    opValid = 1'b1;
    opByte  = op;
    @(negedge clk);
    opValid = 1'b0;
    opByte  = ~op;
  endtask

  task automatic run(input string tag, input logic [7:0] op,
                     input logic [3:0] eCls, input logic [3:0] eSrc,
                     input logic [3:0] eDst, input logic [2:0] eAlu,
                     input logic [1:0] ePair, input logic eDisp,
                     input logic [1:0] eImm, input logic [4:0] eCyc);
    issue(op);
    chk(tag, op, eCls, eSrc, eDst, eAlu, ePair, eDisp, eImm, eCyc);
  endtask

  task automatic testReset();
    checks++;
    if ({decDone, opClass, srcSel, dstSel, aluOp, pairSel, needDisp, immBytes, cycleCount} !==
        {1'b0, 4'd0, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd0}) begin
      errors++;
      $display("FAIL R1 reset act done=%0b cls=%0d src=%0d dst=%0d cyc=%0d exp done=0 cls=0 src=15 dst=15 cyc=0",
               decDone, opClass, srcSel, dstSel, cycleCount);
    end
  endtask

  task automatic testTiming();
    run("R2", 8'hE5, 4'd5, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd15);
    @(negedge clk);
    checks++;
    if (decDone !== 1'b0 || opClass !== 4'd5 || cycleCount !== 5'd15) begin
      errors++;
      $display("FAIL R2 hold act done=%0b cls=%0d cyc=%0d exp done=0 cls=5 cyc=15",
               decDone, opClass, cycleCount);
    end
    // back-to-back strobes
    @(negedge clk);
    opValid = 1'b1; opByte = 8'hE1;
    @(negedge clk);
    opByte = 8'hE9;
    chk("R2", 8'hE1, 4'd5, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd14);
    @(negedge clk);
    opValid = 1'b0;
    chk("R2", 8'hE9, 4'd6, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
  endtask

  task automatic testMoves();
    run("R3", 8'h44, 4'd1, 4'd8, 4'd0, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R3", 8'h6C, 4'd1, 4'd8, 4'd9, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R3", 8'h67, 4'd1, 4'd7, 4'd8, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R3", 8'h40, 4'd1, 4'd0, 4'd0, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R4", 8'h66, 4'd4, 4'd6, 4'd4, 3'd0, 2'd0, 1'b1, 2'd0, 5'd19);
    run("R4", 8'h75, 4'd4, 4'd5, 4'd6, 3'd0, 2'd0, 1'b1, 2'd0, 5'd19);
    run("R4", 8'h7E, 4'd4, 4'd6, 4'd7, 3'd0, 2'd0, 1'b1, 2'd0, 5'd19);
    run("R4", 8'h76, 4'd9, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd0);
  endtask

  task automatic testAlu();
    for (int k = 0; k < 8; k++) begin
      run("R5", 8'h84 | 8'(k << 3), 4'd2, 4'd8, 4'd7, 3'(k), 2'd0, 1'b0, 2'd0, 5'd8);
    end
    run("R5", 8'hAD, 4'd2, 4'd9, 4'd7, 3'd5, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R5", 8'h9E, 4'd2, 4'd6, 4'd7, 3'd3, 2'd0, 1'b1, 2'd0, 5'd19);
    run("R5", 8'hB7, 4'd9, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd0);
  endtask

  task automatic testWide();
    run("R6", 8'h09, 4'd3, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd15);
    run("R6", 8'h39, 4'd3, NONE, NONE, 3'd0, 2'd3, 1'b0, 2'd0, 5'd15);
    run("R7", 8'h21, 4'd4, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd2, 5'd14);
    run("R7", 8'h2A, 4'd4, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd2, 5'd20);
    run("R7", 8'h22, 4'd4, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd2, 5'd20);
    run("R7", 8'h2E, 4'd4, NONE, 4'd9, 3'd0, 2'd0, 1'b0, 2'd1, 5'd11);
    run("R7", 8'hF9, 4'd4, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd10);
    run("R8", 8'h36, 4'd4, NONE, 4'd6, 3'd0, 2'd0, 1'b1, 2'd1, 5'd19);
    run("R9", 8'hE3, 4'd5, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd23);
  endtask

  task automatic testIncDec();
    run("R10", 8'h2B, 4'd7, NONE, NONE, 3'd1, 2'd0, 1'b0, 2'd0, 5'd10);
    run("R10", 8'h23, 4'd7, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd10);
    run("R10", 8'h25, 4'd7, 4'd8, 4'd8, 3'd1, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R10", 8'h2C, 4'd7, 4'd9, 4'd9, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R10", 8'h35, 4'd7, 4'd6, 4'd6, 3'd1, 2'd0, 1'b1, 2'd0, 5'd23);
  endtask

  task automatic testPrefixes();
    run("R11", 8'hCB, 4'd8, NONE, NONE, 3'd0, 2'd0, 1'b1, 2'd0, 5'd0);
    run("R11", 8'hDD, 4'd0, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R11", 8'hFD, 4'd0, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
    run("R11", 8'h00, 4'd0, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd8);
  endtask

  function automatic bit listed(input logic [7:0] op);
    logic [2:0] hi, lo;
    hi = op[5:3];
    lo = op[2:0];
    if (op[7:6] == 2'b01)
      return (op != 8'h76) && (op == 8'h40 || (hi >= 4 && hi <= 6) || (lo >= 4 && lo <= 6));
    if (op[7:6] == 2'b10)
      return (lo >= 4 && lo <= 6);
    case (op)
      8'h00, 8'h09, 8'h19, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h29,
      8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h34, 8'h35, 8'h36, 8'h39, 8'hCB,
      8'hDD, 8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9, 8'hFD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic testSweep();
    for (int v = 0; v < 256; v++) begin
      issue(8'(v));
      if (listed(8'(v))) begin
        checks++;
        if (opClass === 4'd9 || decDone !== 1'b1) begin
          errors++;
          $display("FAIL R12 op=%02h act cls=%0d done=%0b exp cls!=9 done=1", v, opClass, decDone);
        end
      end else begin
        chk("R12", 8'(v), 4'd9, NONE, NONE, 3'd0, 2'd0, 1'b0, 2'd0, 5'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    testMoves();
    testAlu();
    testWide();
    testIncDec();
    testPrefixes();
    testSweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule